// File: doc/BRIEF.md
# Status and Width Mode Controller

This block keeps the 8-bit processor status word, the emulation flag, the high bytes of the two index registers and the high byte of the stack pointer. It carries out the bookkeeping side of a small group of flag instructions: exchanging carry with the emulation flag, clearing or setting status bits under an immediate mask, and loading the whole status word from a byte pulled off the stack. Operand fetch, the stack read itself and the ALU are outside the block. They present the already fetched byte on `operand` together with a 3-bit command.

A command is taken on a rising edge where `cmd_valid` and `ready` are both high. The exchange and the register loads take effect on that edge. The mask operations spend one idle cycle and the status pull spends two, during which `ready` is low. The accumulator-width and index-width mode signals come straight from status bits 5 and 4, so the datapath around the block sees a width change as soon as the status register changes. Emulation mode pins both width bits and the stack page. Eight-bit index mode pins the index high bytes to zero.

Command codes: 0 no-op, 1 exchange carry/emulation, 2 clear masked bits, 3 set masked bits, 4 pull status, 5 load index-X high byte, 6 load index-Y high byte, 7 load stack high byte.

Top module: `status_mode_ctrl`

## Requirements
- R1: After synchronous reset the block is in emulation mode (`emu_mode`=1), `status`=0x34, `stack_hi`=0x01, both index high bytes are 0 and `ready`=1.
- R2: Command 1 swaps status bit 0 (carry) with the emulation flag. The result is visible right after the accepting edge, and `ready` stays high.
- R3: Whenever the emulation flag is 1, status bits 5 and 4 read 1 and `stack_hi` reads 0x01. This includes the state just after entering emulation through command 1.
- R4: Command 2 gives status AND NOT operand, and command 3 gives status OR operand. In emulation the result is also ORed with 0x30. `ready` is low for exactly one cycle after acceptance, the status is unchanged during that cycle, and the new value appears after the next edge.
- R5: Command 4 loads status from the operand unchanged in native mode, or the operand ORed with 0x30 in emulation. `ready` is low for two cycles, the status is unchanged during them, and the new value appears after the second idle edge.
- R6: Whenever status bit 4 is 1, both index high bytes read 0. Setting bit 4 by any command discards their previous contents, and commands 5 and 6 have no effect while bit 4 is 1.
- R7: `acc_8bit` equals status bit 5 and `idx_8bit` equals status bit 4 in every cycle.
- R8: Command 7 loads `stack_hi` from the operand in native mode and has no effect in emulation mode.
- R9: A command presented while `ready` is low is ignored, and command 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd | input | 3 | Command code |
| operand | input | 8 | Mask, pulled byte or load value |
| ready | output | 1 | Block can accept a command |
| status | output | 8 | Processor status word |
| emu_mode | output | 1 | Emulation flag |
| x_hi | output | 8 | Index-X high byte |
| y_hi | output | 8 | Index-Y high byte |
| stack_hi | output | 8 | Stack pointer high byte |
| acc_8bit | output | 1 | 8-bit accumulator mode |
| idx_8bit | output | 1 | 8-bit index mode |

## Verification
The hardest state to reach from the ports is a native-mode block with 16-bit index mode and non-zero index high bytes. Reset leaves the block in emulation, where the index-width bit is pinned. The stimulus first clears carry with command 2 in emulation, exchanges into native mode, and clears bit 4. It then loads the high bytes and finally sets bit 4 again, either by mask, by pull or by re-entering emulation, to show that the bytes are lost. Random command streams then revisit this path many times, with junk commands driven during the idle cycles.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int DW       = 8;
    localparam int CMD_W    = 3;
    localparam int CNT_W    = 2;
    localparam int BIT_C    = 0;
    localparam int BIT_X8   = 4;
    localparam int BIT_M8   = 5;

    localparam logic [DW-1:0] WIDTH_FORCE = 8'h30;
    localparam logic [DW-1:0] STACK_PAGE  = 8'h01;
    localparam logic [DW-1:0] STATUS_RST  = 8'h34;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP  = 3'd0,
        CMD_XCHG = 3'd1,
        CMD_CLRB = 3'd2,
        CMD_SETB = 3'd3,
        CMD_PULL = 3'd4,
        CMD_LDXH = 3'd5,
        CMD_LDYH = 3'd6,
        CMD_LDSH = 3'd7
    } cmd_e;

    typedef struct packed {
        cmd_e          code;
        logic [DW-1:0] arg;
    } op_t;

    typedef struct packed {
        logic [DW-1:0] status;
        logic          emu;
        logic [DW-1:0] xhi;
        logic [DW-1:0] yhi;
        logic [DW-1:0] shi;
    } ctx_t;

    // Idle cycles spent between acceptance and the state update.
    function automatic logic [CNT_W-1:0] idle_cycles(cmd_e c);
        case (c)
            CMD_CLRB, CMD_SETB: return CNT_W'(1);
            CMD_PULL:           return CNT_W'(2);
            default:            return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] emu_fix(logic [DW-1:0] v, logic emu);
        return emu ? (v | WIDTH_FORCE) : v;
    endfunction

endpackage

// File: rtl/smc_sequencer.sv
module smc_sequencer
    import smc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  cmd_e             cmd,
    input  logic [DW-1:0]    operand,
    output logic             ready,
    output logic             apply,
    output op_t              apply_op
);

    logic [CNT_W-1:0] cnt;
    op_t              held;
    logic             accept;
    logic [CNT_W-1:0] lat;

    assign ready  = (cnt == '0);
    assign accept = cmd_valid && ready;
    assign lat    = idle_cycles(cmd);

    always_comb begin
        apply    = 1'b0;
        apply_op = held;
        if (cnt == CNT_W'(1)) begin
            apply = 1'b1;
        end else if (accept && (lat == '0)) begin
            apply    = 1'b1;
            apply_op = '{code: cmd, arg: operand};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '{code: CMD_NOP, arg: '0};
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end else if (accept && (lat != '0)) begin
            cnt  <= lat;
            held <= '{code: cmd, arg: operand};
        end
    end

endmodule

// File: rtl/smc_next_state.sv
module smc_next_state
    import smc_pkg::*;
(
    input  ctx_t cur,
    input  logic apply,
    input  op_t  op,
    output ctx_t nxt
);

    always_comb begin
        nxt = cur;
        if (apply) begin
            case (op.code)
                CMD_XCHG: begin
                    nxt.emu           = cur.status[BIT_C];
                    nxt.status[BIT_C] = cur.emu;
                    if (cur.status[BIT_C]) begin
                        nxt.status = nxt.status | WIDTH_FORCE;
                        nxt.shi    = STACK_PAGE;
                    end
                end
                CMD_CLRB: nxt.status = emu_fix(cur.status & ~op.arg, cur.emu);
                CMD_SETB: nxt.status = emu_fix(cur.status | op.arg, cur.emu);
                CMD_PULL: nxt.status = emu_fix(op.arg, cur.emu);
                CMD_LDXH: nxt.xhi    = op.arg;
                CMD_LDYH: nxt.yhi    = op.arg;
                CMD_LDSH: if (!cur.emu) nxt.shi = op.arg;
                default:  nxt = cur;
            endcase
        end
        if (nxt.status[BIT_X8]) begin
            nxt.xhi = '0;
            nxt.yhi = '0;
        end
    end

endmodule

// File: rtl/smc_state_regs.sv
module smc_state_regs
    import smc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctx_t nxt,
    output ctx_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.status <= STATUS_RST;
            cur.emu    <= 1'b1;
            cur.xhi    <= '0;
            cur.yhi    <= '0;
            cur.shi    <= STACK_PAGE;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/status_mode_ctrl.sv
module status_mode_ctrl
    import smc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd,
    input  logic [7:0]    operand,
    output logic          ready,
    output logic [7:0]    status,
    output logic          emu_mode,
    output logic [7:0]    x_hi,
    output logic [7:0]    y_hi,
    output logic [7:0]    stack_hi,
    output logic          acc_8bit,
    output logic          idx_8bit
);

    logic apply;
    op_t  apply_op;
    ctx_t cur;
    ctx_t nxt;

    smc_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd_e'(cmd)),
        .operand   (operand),
        .ready     (ready),
        .apply     (apply),
        .apply_op  (apply_op)
    );

    smc_next_state u_next (
        .cur   (cur),
        .apply (apply),
        .op    (apply_op),
        .nxt   (nxt)
    );

    smc_state_regs u_regs (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    assign status   = cur.status;
    assign emu_mode = cur.emu;
    assign x_hi     = cur.xhi;
    assign y_hi     = cur.yhi;
    assign stack_hi = cur.shi;
    assign acc_8bit = cur.status[BIT_M8];
    assign idx_8bit = cur.status[BIT_X8];

endmodule

// File: rtl/smc_checker.sv
module smc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd,
    input logic       ready,
    input logic [7:0] status,
    input logic       emu_mode,
    input logic [7:0] x_hi,
    input logic [7:0] y_hi,
    input logic [7:0] stack_hi
);

    AST_XCHG_SWAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ready && cmd == 3'd1) |=> (emu_mode == $past(status[0]) && status[0] == $past(emu_mode))); // R2
    AST_EMU_WIDTH: assert property (@(posedge clk) disable iff (rst)
        emu_mode |-> (status[5:4] == 2'b11)); // R3
    AST_EMU_STACK: assert property (@(posedge clk) disable iff (rst)
        emu_mode |-> (stack_hi == 8'h01)); // R3
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ready && (cmd == 3'd2 || cmd == 3'd3)) |=> (!ready && $stable(status)) ##1 ready); // R4
    AST_PULL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ready && cmd == 3'd4) |=> !ready ##1 (!ready && $stable(status)) ##1 ready); // R5
    AST_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> (x_hi == 8'h00 && y_hi == 8'h00)); // R6

endmodule

bind status_mode_ctrl smc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .ready     (ready),
    .status    (status),
    .emu_mode  (emu_mode),
    .x_hi      (x_hi),
    .y_hi      (y_hi),
    .stack_hi  (stack_hi)
);

// File: tb/status_mode_ctrl_bench.sv
`timescale 1ns/1ps
module status_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [7:0] operand = 8'h00;
    logic       ready;
    logic [7:0] status;
    logic       emu_mode;
    logic [7:0] x_hi;
    logic [7:0] y_hi;
    logic [7:0] stack_hi;
    logic       acc_8bit;
    logic       idx_8bit;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] m_p;
    logic       m_e;
    logic [7:0] m_xh;
    logic [7:0] m_yh;
    logic [7:0] m_sh;

    always #2 clk = ~clk;

    status_mode_ctrl u_status_mode_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .operand(operand),
        .ready(ready), .status(status), .emu_mode(emu_mode), .x_hi(x_hi), .y_hi(y_hi),
        .stack_hi(stack_hi), .acc_8bit(acc_8bit), .idx_8bit(idx_8bit)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int idle_of(logic [2:0] c);
        if (c == 3'd2 || c == 3'd3) return 1;
        if (c == 3'd4) return 2;
        return 0;
    endfunction

    // Expected-state update written from the requirements.
    task automatic model(logic [2:0] c, logic [7:0] o);
        logic t;
        case (c)
            3'd1: begin
                t = m_p[0]; m_p[0] = m_e; m_e = t;
                if (m_e) begin m_p = m_p | 8'h30; m_sh = 8'h01; end
            end
            3'd2: m_p = (m_p & ~o) | (m_e ? 8'h30 : 8'h00);
            3'd3: m_p = (m_p | o) | (m_e ? 8'h30 : 8'h00);
            3'd4: m_p = o | (m_e ? 8'h30 : 8'h00);
            3'd5: m_xh = o;
            3'd6: m_yh = o;
            3'd7: if (!m_e) m_sh = o;
            default: ;
        endcase
        if (m_p[4]) begin m_xh = 8'h00; m_yh = 8'h00; end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R4 R5 status"}, status, m_p);
        chk({tag, " R2 emu"}, emu_mode, m_e);
        chk({tag, " R6 x_hi"}, x_hi, m_xh);
        chk({tag, " R6 y_hi"}, y_hi, m_yh);
        chk({tag, " R3 R8 stack_hi"}, stack_hi, m_sh);
        chk({tag, " R7 acc_8bit"}, acc_8bit, m_p[5]);
        chk({tag, " R7 idx_8bit"}, idx_8bit, m_p[4]);
        chk({tag, " R9 ready"}, ready, 1);
    endtask

    task automatic do_cmd(logic [2:0] c, logic [7:0] o, string tag);
        int lat;
        lat = idle_of(c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; operand = o;
        @(negedge clk);
        for (int i = 0; i < lat; i++) begin
            chk({tag, " R4 R5 ready low"}, ready, 0);
            chk({tag, " R4 R5 status held"}, status, m_p);
            cmd_valid = 1'b1;          // junk during idle, must be ignored (R9)
            cmd = 3'($urandom_range(1, 7));
            operand = 8'($urandom);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        model(c, o);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        m_p = 8'h34; m_e = 1'b1; m_xh = 8'h00; m_yh = 8'h00; m_sh = 8'h01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // Emulation: loads of index high bytes are ignored (R6), stack load ignored (R8)
        do_cmd(3'd5, 8'hAB, "R6 x load in emu");
        do_cmd(3'd7, 8'h22, "R8 stack load in emu");
        do_cmd(3'd2, 8'hFF, "R4 clear all in emu");
        do_cmd(3'd3, 8'h01, "R4 set carry");
        do_cmd(3'd2, 8'h01, "R4 clear carry");
        do_cmd(3'd1, 8'h00, "R2 leave emulation");
        do_cmd(3'd2, 8'h30, "R4 wide modes");
        do_cmd(3'd5, 8'h12, "R6 x load native");
        do_cmd(3'd6, 8'h34, "R6 y load native");
        do_cmd(3'd7, 8'h1F, "R8 stack load native");
        do_cmd(3'd0, 8'hFF, "R9 nop");
        do_cmd(3'd3, 8'h10, "R6 set x8 loses bytes");
        do_cmd(3'd2, 8'h10, "R6 clear x8");
        do_cmd(3'd5, 8'h77, "R6 reload x");
        do_cmd(3'd4, 8'hC1, "R5 pull native x8 clear");
        do_cmd(3'd4, 8'h5A, "R5 pull native sets x8");
        do_cmd(3'd4, 8'h01, "R5 pull native carry");
        do_cmd(3'd5, 8'h99, "R6 load x again");
        do_cmd(3'd1, 8'h00, "R3 enter emulation");
        do_cmd(3'd4, 8'h00, "R5 pull in emu");

        for (int n = 0; n < 600; n++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) c = 3'd1;
            do_cmd(c, 8'($urandom), "rand");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule